// File: doc/BRIEF.md
# Framed Command Packet Parser

The parser accepts a stream of 9-bit symbols and turns it into decoded commands. A symbol whose top bit is clear carries one data byte in its low eight bits. A symbol whose top bit is set is a control symbol. Three control symbols delimit the stream: open-frame, close-frame and negative-acknowledge. Two others, idle and attention, may appear anywhere and are passed over. Inside an open frame, data bytes are grouped into commands. Each command starts with a command byte whose low bits choose one of four layouts. It ends with a check byte, which must equal an 8-bit CRC run over the data bytes received since the last framing symbol.

For every command whose check byte matches, the parser raises a one-cycle strobe together with the command byte, the layout, the address, the 16-bit data word and the count. Any field that the layout does not carry reads as zero. A check mismatch produces an error strobe instead. So do an undefined layout and a framing symbol that cuts a command short. Data bytes arriving while no frame is open are discarded and flagged. Executing the commands and building replies are left to the blocks downstream.

The symbol input is a valid/ready stream. A sender presents a symbol with `sym_valid_i` and keeps both the symbol and `sym_valid_i` steady until `ready_o` is high. A symbol is consumed on a clock edge where both are high. The parser applies back-pressure for exactly one cycle after each check byte. During that cycle it presents the result strobe.

Top module: `fcp_parser`

## Requirements
- R1: A symbol is consumed on a rising edge where `sym_valid_i` and `ready_o` are both high. `ready_o` is low for exactly the one cycle after a check byte is consumed, and high in every other cycle after reset.
- R2: Control symbols have bit 8 set. Their low byte is 0x00 for idle, 0x01 for open-frame, 0x02 for close-frame, 0x03 for negative-acknowledge and 0x04 for attention. A symbol with bit 8 set and any other low byte pulses `oof_o` for one cycle and has no other effect.
- R3: Bits 2:0 of the command byte select the layout that follows it. 0 means check byte only. 1 means address, then check byte. 2 means address, data-low, data-high, then check byte. 3 means address, count, then check byte. `layout_o` reports the value.
- R4: The data word is carried low byte first, so `data_o[7:0]` is the first data byte and `data_o[15:8]` the second.
- R5: The CRC uses polynomial 0x07, starts at zero and takes each byte most significant bit first. It is cleared by open-frame, close-frame and negative-acknowledge, and runs over every non-check data byte after that, across consecutive commands in one frame.
- R6: A matching check byte gives a one-cycle `cmd_valid_o` in the cycle after the check byte is consumed. The field outputs are valid in that cycle, and any field outside the layout reads as zero.
- R7: A check byte that does not match, such as the bitwise inverse of the correct value, gives `err_valid_o` with `err_code_o` = 1 and no `cmd_valid_o`.
- R8: A command byte with bits 2:0 above 3 gives `err_valid_o` with `err_code_o` = 2 in the following cycle. Later data bytes are then dropped silently until the next open-frame, close-frame or negative-acknowledge.
- R9: An open-frame, close-frame or negative-acknowledge that arrives after a command byte and before its check byte aborts the command and gives `err_valid_o` with `err_code_o` = 2.
- R10: A data byte consumed while no frame is open pulses `oof_o` and does not change the CRC or any command.
- R11: Idle and attention symbols are consumed with no effect on the CRC, the parse position or any output, even in the middle of a command.
- R12: While and after reset, no frame is open, `ready_o` is high and `cmd_valid_o`, `err_valid_o` and `oof_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_i | input | 9 | Input symbol; bit 8 marks control |
| sym_valid_i | input | 1 | Symbol present |
| ready_o | output | 1 | Parser accepts a symbol this cycle |
| cmd_valid_o | output | 1 | One-cycle strobe for a good command |
| cmd_o | output | 8 | Command byte |
| layout_o | output | 2 | Layout selected by the command byte |
| addr_o | output | 8 | Address byte, zero if absent |
| data_o | output | 16 | Data word, zero if absent |
| count_o | output | 8 | Count byte, zero if absent |
| err_valid_o | output | 1 | One-cycle error strobe |
| err_code_o | output | 2 | 1 = check mismatch, 2 = format error |
| oof_o | output | 1 | One-cycle strobe for a dropped out-of-frame symbol |

## Verification
The bound checker watches four things on every cycle. Back-pressure lasts one cycle and coincides with a check-byte result. Command and error strobes never overlap. A command strobe always follows a consumed data symbol. Format errors never stall the stream. The bench's behavioural model follows each symbol and compares every output on every clock. It is the only place where the field values, the CRC kept across commands within a frame, and the silent dropping after an undefined layout are shown. The same holds for the inverted-check case and for idle and attention symbols placed in the middle of a command.

// File: rtl/fcp_pkg.sv
package fcp_pkg;

  typedef enum logic [2:0] {
    SK_DATA,
    SK_SOP,
    SK_EOP,
    SK_NAK,
    SK_IDLE,
    SK_ATTN,
    SK_BAD
  } sym_kind_t;

  typedef enum logic [3:0] {
    ST_OUT,
    ST_CMD,
    ST_ADDR,
    ST_DLO,
    ST_DHI,
    ST_CNT,
    ST_CRC,
    ST_HOLD,
    ST_SKIP
  } seq_state_t;

  typedef enum logic [1:0] {
    LY_CMD  = 2'd0,
    LY_ADDR = 2'd1,
    LY_DATA = 2'd2,
    LY_CNT  = 2'd3
  } layout_t;

  localparam logic [1:0] ERR_CRC = 2'd1;
  localparam logic [1:0] ERR_FMT = 2'd2;

endpackage

// File: rtl/fcp_sym_class.sv
module fcp_sym_class
  import fcp_pkg::*;
#(
  parameter int                 BYTE_W    = 8,
  parameter logic [BYTE_W-1:0]  IDLE_CODE = 'h00,
  parameter logic [BYTE_W-1:0]  SOP_CODE  = 'h01,
  parameter logic [BYTE_W-1:0]  EOP_CODE  = 'h02,
  parameter logic [BYTE_W-1:0]  NAK_CODE  = 'h03,
  parameter logic [BYTE_W-1:0]  ATTN_CODE = 'h04
) (
  input  logic [BYTE_W:0] sym_i,
  output sym_kind_t       kind_o
);

  logic [BYTE_W-1:0] low;
  assign low = sym_i[BYTE_W-1:0];

  always_comb begin
    if (!sym_i[BYTE_W])          kind_o = SK_DATA;
    else if (low == SOP_CODE)    kind_o = SK_SOP;
    else if (low == EOP_CODE)    kind_o = SK_EOP;
    else if (low == NAK_CODE)    kind_o = SK_NAK;
    else if (low == IDLE_CODE)   kind_o = SK_IDLE;
    else if (low == ATTN_CODE)   kind_o = SK_ATTN;
    else                         kind_o = SK_BAD;
  end

endmodule

// File: rtl/fcp_crc8.sv
module fcp_crc8 #(
  parameter int                 W    = 8,
  parameter logic [W-1:0]       POLY = 'h07
) (
  input  logic [W-1:0] crc_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] crc_o
);

  // whole byte folded in, then W shift steps, MSB first
  always_comb begin
    logic [W-1:0] c;
    c = crc_i ^ byte_i;
    for (int i = 0; i < W; i++) begin
      if (c[W-1]) c = (c << 1) ^ POLY;
      else        c = c << 1;
    end
    crc_o = c;
  end

endmodule

// File: rtl/fcp_seq.sv
module fcp_seq
  import fcp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire_i,
  input  sym_kind_t             kind_i,
  input  logic [BYTE_W-1:0]     byte_i,
  input  logic [BYTE_W-1:0]     crc_next_i,
  output logic [BYTE_W-1:0]     crc_q_o,
  output logic                  hold_o,
  output logic                  cmd_stb_o,
  output logic                  err_stb_o,
  output logic [1:0]            err_code_o,
  output logic                  oof_o,
  output logic [BYTE_W-1:0]     cmd_o,
  output layout_t               layout_o,
  output logic [BYTE_W-1:0]     addr_o,
  output logic [2*BYTE_W-1:0]   data_o,
  output logic [BYTE_W-1:0]     cnt_o
);

  localparam int WORD_W  = 2 * BYTE_W;
  localparam int LAYOUTS = 4;

  seq_state_t          st_q, st_n;
  logic [BYTE_W-1:0]   crc_q, crc_n;
  layout_t             lay_q, lay_n;
  logic [BYTE_W-1:0]   cmd_q, cmd_n, addr_q, addr_n, cnt_q, cnt_n;
  logic [WORD_W-1:0]   data_q, data_n;
  logic                good, crc_bad, fmt_bad, oof;
  logic                mid;

  assign mid = (st_q == ST_ADDR) || (st_q == ST_DLO) || (st_q == ST_DHI) ||
               (st_q == ST_CNT)  || (st_q == ST_CRC);

  always_comb begin
    st_n    = st_q;
    crc_n   = crc_q;
    lay_n   = lay_q;
    cmd_n   = cmd_q;
    addr_n  = addr_q;
    data_n  = data_q;
    cnt_n   = cnt_q;
    good    = 1'b0;
    crc_bad = 1'b0;
    fmt_bad = 1'b0;
    oof     = 1'b0;
    if (st_q == ST_HOLD) begin
      st_n = ST_CMD;
    end else if (fire_i) begin
      case (kind_i)
        SK_SOP: begin
          fmt_bad = mid;
          st_n    = ST_CMD;
          crc_n   = '0;
        end
        SK_EOP: begin
          fmt_bad = mid;
          st_n    = ST_OUT;
          crc_n   = '0;
        end
        SK_NAK: begin
          fmt_bad = mid;
          st_n    = (st_q == ST_OUT) ? ST_OUT : ST_CMD;
          crc_n   = '0;
        end
        SK_BAD: oof = 1'b1;
        SK_DATA: begin
          case (st_q)
            ST_OUT: oof = 1'b1;
            ST_CMD: begin
              crc_n  = crc_next_i;
              cmd_n  = byte_i;
              addr_n = '0;
              data_n = '0;
              cnt_n  = '0;
              if (byte_i[SEL_W-1:0] > SEL_W'(LAYOUTS - 1)) begin
                fmt_bad = 1'b1;
                st_n    = ST_SKIP;
              end else begin
                lay_n = layout_t'(byte_i[1:0]);
                st_n  = (byte_i[1:0] == LY_CMD) ? ST_CRC : ST_ADDR;
              end
            end
            ST_ADDR: begin
              crc_n  = crc_next_i;
              addr_n = byte_i;
              case (lay_q)
                LY_DATA: st_n = ST_DLO;
                LY_CNT:  st_n = ST_CNT;
                default: st_n = ST_CRC;
              endcase
            end
            ST_DLO: begin
              crc_n              = crc_next_i;
              data_n[BYTE_W-1:0] = byte_i;
              st_n               = ST_DHI;
            end
            ST_DHI: begin
              crc_n                   = crc_next_i;
              data_n[WORD_W-1:BYTE_W] = byte_i;
              st_n                    = ST_CRC;
            end
            ST_CNT: begin
              crc_n = crc_next_i;
              cnt_n = byte_i;
              st_n  = ST_CRC;
            end
            ST_CRC: begin
              if (byte_i == crc_q) good = 1'b1;
              else                 crc_bad = 1'b1;
              st_n = ST_HOLD;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_OUT;
      crc_q      <= '0;
      lay_q      <= LY_CMD;
      cmd_q      <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      cnt_q      <= '0;
      cmd_stb_o  <= 1'b0;
      err_stb_o  <= 1'b0;
      err_code_o <= '0;
      oof_o      <= 1'b0;
    end else begin
      st_q       <= st_n;
      crc_q      <= crc_n;
      lay_q      <= lay_n;
      cmd_q      <= cmd_n;
      addr_q     <= addr_n;
      data_q     <= data_n;
      cnt_q      <= cnt_n;
      cmd_stb_o  <= good;
      err_stb_o  <= crc_bad | fmt_bad;
      err_code_o <= crc_bad ? ERR_CRC : (fmt_bad ? ERR_FMT : 2'd0);
      oof_o      <= oof;
    end
  end

  assign hold_o   = (st_q == ST_HOLD);
  assign crc_q_o  = crc_q;
  assign cmd_o    = cmd_q;
  assign layout_o = lay_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/fcp_parser.sv
module fcp_parser
  import fcp_pkg::*;
#(
  parameter int                 BYTE_W    = 8,
  parameter logic [BYTE_W-1:0]  CRC_POLY  = 'h07,
  parameter logic [BYTE_W-1:0]  IDLE_CODE = 'h00,
  parameter logic [BYTE_W-1:0]  SOP_CODE  = 'h01,
  parameter logic [BYTE_W-1:0]  EOP_CODE  = 'h02,
  parameter logic [BYTE_W-1:0]  NAK_CODE  = 'h03,
  parameter logic [BYTE_W-1:0]  ATTN_CODE = 'h04
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BYTE_W:0]       sym_i,
  input  logic                  sym_valid_i,
  output logic                  ready_o,
  output logic                  cmd_valid_o,
  output logic [BYTE_W-1:0]     cmd_o,
  output logic [1:0]            layout_o,
  output logic [BYTE_W-1:0]     addr_o,
  output logic [2*BYTE_W-1:0]   data_o,
  output logic [BYTE_W-1:0]     count_o,
  output logic                  err_valid_o,
  output logic [1:0]            err_code_o,
  output logic                  oof_o
);

  sym_kind_t          kind;
  logic               fire, hold;
  logic [BYTE_W-1:0]  crc_q, crc_next;
  layout_t            lay;

  assign ready_o = !hold;
  assign fire    = sym_valid_i && ready_o;

  fcp_sym_class #(
    .BYTE_W(BYTE_W), .IDLE_CODE(IDLE_CODE), .SOP_CODE(SOP_CODE),
    .EOP_CODE(EOP_CODE), .NAK_CODE(NAK_CODE), .ATTN_CODE(ATTN_CODE)
  ) u_class (
    .sym_i (sym_i),
    .kind_o(kind)
  );

  fcp_crc8 #(.W(BYTE_W), .POLY(CRC_POLY)) u_crc (
    .crc_i (crc_q),
    .byte_i(sym_i[BYTE_W-1:0]),
    .crc_o (crc_next)
  );

  fcp_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire),
    .kind_i    (kind),
    .byte_i    (sym_i[BYTE_W-1:0]),
    .crc_next_i(crc_next),
    .crc_q_o   (crc_q),
    .hold_o    (hold),
    .cmd_stb_o (cmd_valid_o),
    .err_stb_o (err_valid_o),
    .err_code_o(err_code_o),
    .oof_o     (oof_o),
    .cmd_o     (cmd_o),
    .layout_o  (lay),
    .addr_o    (addr_o),
    .data_o    (data_o),
    .cnt_o     (count_o)
  );

  assign layout_o = lay;

endmodule

// File: rtl/fcp_parser_chk.sv
module fcp_parser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_ctl_i,
  input logic       sym_valid_i,
  input logic       ready_o,
  input logic       cmd_valid_o,
  input logic       err_valid_o,
  input logic [1:0] err_code_o,
  input logic       oof_o
);

  // R1
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |=> ready_o);

  // R1
  busy_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> (cmd_valid_o || (err_valid_o && err_code_o == 2'd1)));

  // R6
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R6
  cmd_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(sym_valid_i && ready_o && !sym_ctl_i));

  // R7
  cmd_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && err_valid_o));

  // R9
  fmt_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid_o && err_code_o == 2'd2) |-> ready_o);

  // R10
  oof_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oof_o |-> $past(sym_valid_i && ready_o));

endmodule

bind fcp_parser fcp_parser_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sym_ctl_i  (sym_i[BYTE_W]),
  .sym_valid_i(sym_valid_i),
  .ready_o    (ready_o),
  .cmd_valid_o(cmd_valid_o),
  .err_valid_o(err_valid_o),
  .err_code_o (err_code_o),
  .oof_o      (oof_o)
);

// File: tb/fcp_parser_bench.sv
`timescale 1ns/1ps
module fcp_parser_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  sym = '0;
  logic        sym_valid = 1'b0;
  logic        ready_o, cmd_valid_o, err_valid_o, oof_o;
  logic [7:0]  cmd_o, addr_o, count_o;
  logic [1:0]  layout_o, err_code_o;
  logic [15:0] data_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fcp_parser u_fcp_parser (
    .clk(clk), .rst_n(rst_n), .sym_i(sym), .sym_valid_i(sym_valid),
    .ready_o(ready_o), .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o),
    .layout_o(layout_o), .addr_o(addr_o), .data_o(data_o), .count_o(count_o),
    .err_valid_o(err_valid_o), .err_code_o(err_code_o), .oof_o(oof_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // bit-serial CRC, polynomial 0x07, MSB first
  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  function automatic int need_len(input logic [1:0] l);
    case (l)
      2'd0: return 2;
      2'd1: return 3;
      2'd2: return 5;
      default: return 4;
    endcase
  endfunction

  // ---------------- behavioural reference model ----------------
  bit          m_hold, m_in, m_skip;
  logic [7:0]  m_crc;
  logic [7:0]  m_q[$];
  bit          e_cmdv, e_errv, e_oof;
  int          e_errc, e_cmd, e_lay, e_addr, e_data, e_cnt;

  task automatic model_step(input logic [8:0] s);
    logic [7:0] b;
    int lay;
    b = s[7:0];
    if (s[8]) begin
      if (b == 8'h01 || b == 8'h02 || b == 8'h03) begin
        if (m_q.size() > 0) begin e_errv = 1; e_errc = 2; end
        m_q.delete();
        m_skip = 0;
        m_crc  = 8'h00;
        if (b == 8'h01) m_in = 1;
        else if (b == 8'h02) m_in = 0;
      end else if (b != 8'h00 && b != 8'h04) begin
        e_oof = 1;
      end
    end else if (!m_in) begin
      e_oof = 1;
    end else if (!m_skip) begin
      if (m_q.size() == 0 && b[2:0] > 3) begin
        e_errv = 1; e_errc = 2; m_skip = 1;
      end else begin
        m_q.push_back(b);
        lay = int'(m_q[0][1:0]);
        if (m_q.size() == need_len(m_q[0][1:0])) begin
          if (b == m_crc) begin
            e_cmdv = 1;
            e_cmd  = int'(m_q[0]);
            e_lay  = lay;
            e_addr = (lay >= 1) ? int'(m_q[1]) : 0;
            e_data = (lay == 2) ? int'({m_q[3], m_q[2]}) : 0;
            e_cnt  = (lay == 3) ? int'(m_q[2]) : 0;
          end else begin
            e_errv = 1; e_errc = 1;
          end
          m_hold = 1;
          m_q.delete();
        end else begin
          m_crc = crc_step(m_crc, b);
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = 0; m_in = 0; m_skip = 0; m_crc = 8'h00; m_q.delete();
      e_cmdv = 0; e_errv = 0; e_oof = 0;
    end else begin
      e_cmdv = 0; e_errv = 0; e_oof = 0;
      if (m_hold) m_hold = 0;
      else if (sym_valid) model_step(sym);
    end
  end

  // ---------------- per-cycle comparison ----------------
  int n_cmd = 0, n_crc = 0, n_fmt = 0, n_oof = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ready_o === !m_hold, "R1 ready", ready_o, !m_hold);
      chk(cmd_valid_o === e_cmdv, "R6 cmd_valid", cmd_valid_o, e_cmdv);
      chk(err_valid_o === e_errv, "R7 R8 R9 err_valid", err_valid_o, e_errv);
      chk(oof_o === e_oof, "R2 R10 oof", oof_o, e_oof);
      if (e_cmdv) begin
        chk(cmd_o == e_cmd, "R6 cmd", cmd_o, e_cmd);
        chk(layout_o == e_lay, "R3 layout", layout_o, e_lay);
        chk(addr_o == e_addr, "R6 addr", addr_o, e_addr);
        chk(data_o == e_data, "R4 data", data_o, e_data);
        chk(count_o == e_cnt, "R6 count", count_o, e_cnt);
      end
      if (e_errv)
        chk(err_code_o == e_errc, (e_errc == 1) ? "R7 err_code" : "R8/R9 err_code",
            err_code_o, e_errc);
      if (cmd_valid_o) n_cmd++;
      if (err_valid_o && err_code_o == 2'd1) n_crc++;
      if (err_valid_o && err_code_o == 2'd2) n_fmt++;
      if (oof_o) n_oof++;
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] tx_crc = 8'h00;

  task automatic put(input logic [8:0] s);
    @(negedge clk);
    sym = s;
    sym_valid = 1'b1;
    while (!ready_o) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic gap(input int n);
    @(negedge clk);
    sym_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_byte(input logic [7:0] b);
    put({1'b0, b});
    tx_crc = crc_step(tx_crc, b);
  endtask

  task automatic tx_ctl(input logic [7:0] code);
    put({1'b1, code});
    if (code == 8'h01 || code == 8'h02 || code == 8'h03) tx_crc = 8'h00;
  endtask

  task automatic tx_check(input bit bad);
    put({1'b0, bad ? ~tx_crc : tx_crc});
  endtask

  task automatic tx_cmd(input logic [7:0] c, input logic [7:0] a,
                        input logic [15:0] d, input logic [7:0] n, input bit bad);
    tx_byte(c);
    if (c[1:0] >= 2'd1) tx_byte(a);
    if (c[1:0] == 2'd2) begin tx_byte(d[7:0]); tx_byte(d[15:8]); end
    if (c[1:0] == 2'd3) tx_byte(n);
    tx_check(bad);
  endtask

  int s_cmd, s_crc, s_fmt, s_oof;
  task automatic snap();
    s_cmd = n_cmd; s_crc = n_crc; s_fmt = n_fmt; s_oof = n_oof;
  endtask

  task automatic expect_counts(input string tag, input int c, input int e,
                               input int f, input int o);
    gap(4);
    chk(n_cmd - s_cmd == c, {tag, " commands"}, n_cmd - s_cmd, c);
    chk(n_crc - s_crc == e, {tag, " crc errors"}, n_crc - s_crc, e);
    chk(n_fmt - s_fmt == f, {tag, " format errors"}, n_fmt - s_fmt, f);
    chk(n_oof - s_oof == o, {tag, " oof"}, n_oof - s_oof, o);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk(ready_o === 1'b1, "R12 ready in reset", ready_o, 1);
    chk(cmd_valid_o === 1'b0, "R12 cmd_valid in reset", cmd_valid_o, 0);
    chk(err_valid_o === 1'b0, "R12 err_valid in reset", err_valid_o, 0);
    chk(oof_o === 1'b0, "R12 oof in reset", oof_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready_o === 1'b1, "R12 ready after reset", ready_o, 1);

    // R10: data before any frame
    snap();
    tx_byte(8'h11);
    tx_byte(8'h22);
    tx_crc = 8'h00;
    expect_counts("R10", 0, 0, 0, 2);

    // R3 R4 R5: all four layouts back to back, CRC running across commands
    snap();
    tx_ctl(8'h01);
    tx_cmd(8'h10, 8'h00, 16'h0000, 8'h00, 0);
    tx_cmd(8'h21, 8'h5A, 16'h0000, 8'h00, 0);
    tx_cmd(8'h32, 8'h33, 16'hBEEF, 8'h00, 0);
    tx_cmd(8'h43, 8'h07, 16'h0000, 8'h09, 0);
    tx_ctl(8'h02);
    expect_counts("R3 R5", 4, 0, 0, 0);

    // R7: inverted check byte, then a good command in the same frame
    snap();
    tx_ctl(8'h01);
    tx_cmd(8'h29, 8'hC3, 16'h0000, 8'h00, 1);
    tx_cmd(8'hF8, 8'h00, 16'h0000, 8'h00, 0);
    tx_ctl(8'h02);
    expect_counts("R7", 1, 1, 0, 0);

    // R8: undefined layout, trailing bytes dropped, NAK restores parsing
    snap();
    tx_ctl(8'h01);
    tx_byte(8'h05);
    tx_byte(8'hAA);
    tx_byte(8'hBB);
    tx_ctl(8'h03);
    tx_cmd(8'h6A, 8'h12, 16'h1234, 8'h00, 0);
    tx_ctl(8'h02);
    expect_counts("R8", 1, 0, 1, 0);

    // R9: close-frame cuts a command short, then a byte outside the frame
    snap();
    tx_ctl(8'h01);
    tx_byte(8'h02);
    tx_byte(8'h10);
    tx_ctl(8'h02);
    tx_byte(8'h44);
    tx_crc = 8'h00;
    expect_counts("R9", 0, 0, 1, 1);

    // R9: open-frame inside a command, then recovery
    snap();
    tx_ctl(8'h01);
    tx_byte(8'h03);
    tx_ctl(8'h01);
    tx_cmd(8'h0B, 8'h77, 16'h0000, 8'hFE, 0);
    tx_ctl(8'h02);
    expect_counts("R9 sop", 1, 0, 1, 0);

    // R11 R2: idle, attention and an unknown control inside a command
    snap();
    tx_ctl(8'h01);
    tx_byte(8'h22);
    tx_ctl(8'h00);
    tx_byte(8'h81);
    tx_ctl(8'h04);
    tx_byte(8'h34);
    tx_ctl(8'hF5);
    tx_byte(8'h12);
    tx_ctl(8'h00);
    tx_check(0);
    tx_ctl(8'h02);
    expect_counts("R11 R2", 1, 0, 0, 1);

    // R1: gaps between symbols, valid dropped mid-command
    snap();
    tx_ctl(8'h01);
    tx_byte(8'h01);
    gap(3);
    tx_byte(8'h99);
    gap(1);
    tx_check(0);
    tx_cmd(8'h00, 8'h00, 16'h0000, 8'h00, 0);
    tx_ctl(8'h02);
    expect_counts("R1", 2, 0, 0, 0);

    // R2: NAK outside a frame keeps the frame closed
    snap();
    tx_ctl(8'h03);
    tx_byte(8'h01);
    tx_crc = 8'h00;
    expect_counts("R2 nak", 0, 0, 0, 1);

    done = 1;
    summary();
    $finish;
  end

endmodule